// File: doc/BRIEF.md
# Byte FIFO with Water-Level Interrupts

A 32-entry byte queue that serves both directions of a half-duplex data path. When sending, a host loads bytes and a framer drains them. When receiving, a demodulator loads bytes and the host drains them. The queue has one write port and one read port. A mode input tells the block which direction is active, and the direction sets the meaning of the water-level interrupt.

The interrupt tells the host when to act. When sending, it fires when too few bytes are left and the host must top the queue up. When receiving, it fires when too many bytes have piled up and the host must empty it. Each direction has two thresholds, and a select bit per direction picks one. The block also reports how many bytes are unread. A sticky flag records that received bytes were lost because the queue was full. A synchronous clear input empties the queue and resets the status.

Top module: `wl_byte_fifo`

## Requirements
- R1: The queue holds up to 32 bytes. Bytes are read out in the order they were written. `fifo_count` always equals the number of bytes written but not yet read.
- R2: While the queue is not empty, `rd_data` shows the oldest byte without delay, and a read pops it. A read while empty leaves the count unchanged, and `rd_data` is 0 whenever the queue is empty.
- R3: A write while the queue holds 32 bytes, with no read in the same cycle, is discarded. If the mode is receive (`rx_mode`=1), that write also sets `ovf_flag`.
- R4: `ovf_flag` stays set until a clear. Reads do not clear it. A discarded write in transmit mode (`rx_mode`=0) does not set it.
- R5: `clr` empties the queue and zeroes `fifo_count` and `ovf_flag` at the next edge. It takes priority over a write or read in the same cycle.
- R6: In transmit mode, `wl_irq` pulses when `fifo_count` changes from at or above the transmit level to below it. The transmit level is 8 when `tx_lvl_sel`=0 and 16 when `tx_lvl_sel`=1.
- R7: In receive mode, `wl_irq` pulses when `fifo_count` changes from at or below the receive level to above it. The receive level is 16 when `rx_lvl_sel`=0 and 24 when `rx_lvl_sel`=1.
- R8: `wl_irq` lasts exactly one cycle for each crossing and does not repeat while the condition persists. No pulse follows reset or a clear, even when the condition already holds then.
- R9: A write and a read in the same cycle both take effect. On a full queue this leaves the count at 32 and does not set `ovf_flag`. On an empty queue the read returns 0 and the written byte is stored.
- R10: After reset the count is 0, `ovf_flag` is 0, `wl_irq` is 0, and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of the contents and status |
| rx_mode | input | 1 | 1 = receive direction, 0 = transmit direction |
| tx_lvl_sel | input | 1 | Transmit threshold select (0: 8, 1: 16) |
| rx_lvl_sel | input | 1 | Receive threshold select (0: 16, 1: 24) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Byte to write |
| rd_en | input | 1 | Read strobe (pops the head) |
| rd_data | output | 8 | Oldest unread byte, 0 when empty |
| fifo_count | output | 6 | Number of unread bytes |
| ovf_flag | output | 1 | Sticky receive-overflow flag |
| wl_irq | output | 1 | Single-cycle water-level interrupt pulse |

## Verification
A push and a pop can land in the same cycle. So can a clear and a push or pop. The collisions that matter are at the edges: a write and a read together on a full queue, where overflow must not be set and the count must stay at 32, and a write and a read together on an empty queue, where the read yields zero while the byte is kept. The bench drives both on purpose, then adds long random stretches in which writes, reads, clears and mode changes collide freely. A queue-based reference model checks every cycle's count, head byte, flag and interrupt pulse.

// File: rtl/wlf_pkg.sv
package wlf_pkg;

   typedef enum logic {
      DIR_TX = 1'b0,
      DIR_RX = 1'b1
   } wlf_dir_e;

   typedef enum logic [1:0] {
      OP_IDLE = 2'b00,
      OP_POP  = 2'b01,
      OP_PUSH = 2'b10,
      OP_BOTH = 2'b11
   } wlf_op_e;

   function automatic bit wlf_is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/wlf_store.sv
module wlf_store
   import wlf_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 32,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              push,
   input  logic              pop,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] head_data,
   output logic [CNT_W-1:0]  count
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [PTR_W-1:0]  wr_nxt, rd_nxt;
   wlf_op_e           op;

   generate
      if (wlf_is_pow2(DEPTH)) begin : g_wrap_pow2
         assign wr_nxt = wr_ptr + PTR_W'(1);
         assign rd_nxt = rd_ptr + PTR_W'(1);
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   assign op        = wlf_op_e'({push, pop});
   assign head_data = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) begin
         mem[wr_ptr] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         unique case (op)
            OP_PUSH: count <= count + CNT_W'(1);
            OP_POP:  count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/wlf_level_irq.sv
module wlf_level_irq
   import wlf_pkg::*;
#(
   parameter int unsigned CNT_W    = 6,
   parameter int unsigned TX_LO    = 8,
   parameter int unsigned TX_HI    = 16,
   parameter int unsigned RX_LO    = 16,
   parameter int unsigned RX_HI    = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [CNT_W-1:0] count,
   input  wlf_dir_e         dir,
   input  logic             tx_sel,
   input  logic             rx_sel,
   output logic             irq
);

   logic [CNT_W-1:0] tx_level, rx_level;
   logic             need_service;
   logic             need_q;

   assign tx_level = tx_sel ? CNT_W'(TX_HI) : CNT_W'(TX_LO);
   assign rx_level = rx_sel ? CNT_W'(RX_HI) : CNT_W'(RX_LO);

   always_comb begin
      unique case (dir)
         DIR_RX:  need_service = (count > rx_level);
         default: need_service = (count < tx_level);
      endcase
   end

   // Starts high so that a condition already true at reset or clear gives no pulse.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         need_q <= 1'b1;
      end else if (clr) begin
         need_q <= 1'b1;
      end else begin
         need_q <= need_service;
      end
   end

   assign irq = need_service & ~need_q;

endmodule

// File: rtl/wlf_ovf_track.sv
module wlf_ovf_track
   import wlf_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     clr,
   input  logic     drop,
   input  wlf_dir_e dir,
   output logic     ovf
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf <= 1'b0;
      end else if (clr) begin
         ovf <= 1'b0;
      end else if (drop && (dir == DIR_RX)) begin
         ovf <= 1'b1;
      end
   end

endmodule

// File: rtl/wl_byte_fifo.sv
module wl_byte_fifo
   import wlf_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned DEPTH      = 32,
   parameter int unsigned TX_LVL_LO  = 8,
   parameter int unsigned TX_LVL_HI  = 16,
   parameter int unsigned RX_LVL_LO  = 16,
   parameter int unsigned RX_LVL_HI  = 24,
   localparam int unsigned CNT_W     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              rx_mode,
   input  logic              tx_lvl_sel,
   input  logic              rx_lvl_sel,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  fifo_count,
   output logic              ovf_flag,
   output logic              wl_irq
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("wl_byte_fifo: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("wl_byte_fifo: DATA_W must be at least 1");
      end
      if (TX_LVL_LO > DEPTH || TX_LVL_HI > DEPTH) begin : g_bad_tx_lvl
         $error("wl_byte_fifo: transmit levels must not exceed DEPTH");
      end
      if (RX_LVL_LO >= DEPTH || RX_LVL_HI >= DEPTH) begin : g_bad_rx_lvl
         $error("wl_byte_fifo: receive levels must be below DEPTH");
      end
   endgenerate

   wlf_dir_e          dir;
   logic              full, empty;
   logic              push, pop, drop;
   logic [DATA_W-1:0] head_data;

   assign dir   = rx_mode ? DIR_RX : DIR_TX;
   assign full  = (fifo_count == CNT_W'(DEPTH));
   assign empty = (fifo_count == '0);

   assign pop  = rd_en & ~empty & ~clr;
   assign push = wr_en & ~clr & (~full | pop);
   assign drop = wr_en & ~clr & full & ~pop;

   assign rd_data = empty ? '0 : head_data;

   wlf_store #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .push      (push),
      .pop       (pop),
      .wdata     (wr_data),
      .head_data (head_data),
      .count     (fifo_count)
   );

   wlf_level_irq #(
      .CNT_W (CNT_W),
      .TX_LO (TX_LVL_LO),
      .TX_HI (TX_LVL_HI),
      .RX_LO (RX_LVL_LO),
      .RX_HI (RX_LVL_HI)
   ) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .count  (fifo_count),
      .dir    (dir),
      .tx_sel (tx_lvl_sel),
      .rx_sel (rx_lvl_sel),
      .irq    (wl_irq)
   );

   wlf_ovf_track u_ovf (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .drop  (drop),
      .dir   (dir),
      .ovf   (ovf_flag)
   );

endmodule

// File: rtl/wlf_checker.sv
module wlf_checker #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 32,
   parameter int unsigned CNT_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr,
   input logic              rx_mode,
   input logic              wr_en,
   input logic              rd_en,
   input logic [DATA_W-1:0] rd_data,
   input logic [CNT_W-1:0]  fifo_count,
   input logic              ovf_flag,
   input logic              wl_irq
);

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_count <= CNT_W'(DEPTH)); // R1

   AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_count == '0) |-> (rd_data == '0)); // R2

   AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_count == '0 && rd_en && !wr_en && !clr) |=> (fifo_count == '0)); // R2

   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_count == CNT_W'(DEPTH) && wr_en && !rd_en && !clr) |=> (fifo_count == CNT_W'(DEPTH))); // R3

   AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_mode && fifo_count == CNT_W'(DEPTH) && wr_en && !rd_en && !clr) |=> ovf_flag); // R3

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !clr) |=> ovf_flag); // R4

   AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (fifo_count == '0 && !ovf_flag && !wl_irq)); // R5

   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wl_irq |=> !wl_irq); // R8

   AST_FULL_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_count == CNT_W'(DEPTH) && wr_en && rd_en && !clr && !ovf_flag)
         |=> (fifo_count == CNT_W'(DEPTH) && !ovf_flag)); // R9

endmodule

bind wl_byte_fifo wlf_checker #(
   .DATA_W (DATA_W),
   .DEPTH  (DEPTH),
   .CNT_W  (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clr        (clr),
   .rx_mode    (rx_mode),
   .wr_en      (wr_en),
   .rd_en      (rd_en),
   .rd_data    (rd_data),
   .fifo_count (fifo_count),
   .ovf_flag   (ovf_flag),
   .wl_irq     (wl_irq)
);

// File: tb/wl_byte_fifo_test.sv
`timescale 1ns/1ps
module wl_byte_fifo_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clr = 1'b0;
   logic       rx_mode = 1'b0;
   logic       tx_lvl_sel = 1'b0;
   logic       rx_lvl_sel = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic [5:0] fifo_count;
   logic       ovf_flag;
   logic       wl_irq;

   int  checks = 0;
   int  failures = 0;
   bit  done = 1'b0;
   int  irq_events = 0;
   int  irq_at = -1;

   logic [7:0] q[$];
   bit  ovf_m = 1'b0;
   bit  prev_m = 1'b1;

   always #2.5 clk = ~clk;

   wl_byte_fifo uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .rx_mode    (rx_mode),
      .tx_lvl_sel (tx_lvl_sel),
      .rx_lvl_sel (rx_lvl_sel),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .rd_en      (rd_en),
      .rd_data    (rd_data),
      .fifo_count (fifo_count),
      .ovf_flag   (ovf_flag),
      .wl_irq     (wl_irq)
   );

   function automatic bit cond_f(int n);
      if (rx_mode) return n > (rx_lvl_sel ? 24 : 16);
      return n < (tx_lvl_sel ? 16 : 8);
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      int  exp_rd;
      bit  exp_irq;
      exp_rd  = (q.size() == 0) ? 0 : int'(q[0]);
      exp_irq = cond_f(q.size()) && !prev_m;
      chk(int'(fifo_count) == q.size(), "R1 count", int'(fifo_count), q.size());
      chk(int'(rd_data) == exp_rd, "R2 rd_data", int'(rd_data), exp_rd);
      chk(ovf_flag == ovf_m, "R3 ovf_flag", int'(ovf_flag), int'(ovf_m));
      chk(wl_irq == exp_irq, rx_mode ? "R7 wl_irq" : "R6 wl_irq", int'(wl_irq), int'(exp_irq));
      if (wl_irq) begin
         irq_events++;
         irq_at = int'(fifo_count);
      end
   endtask

   task automatic cyc();
      int  n;
      bit  popd;
      @(posedge clk);
      n = q.size();
      if (clr) begin
         q.delete();
         ovf_m  = 1'b0;
         prev_m = 1'b1;
      end else begin
         prev_m = cond_f(n);
         popd = rd_en && (n > 0);
         if (popd) void'(q.pop_front());
         if (wr_en) begin
            if (n < 32 || popd) q.push_back(wr_data);
            else if (rx_mode) ovf_m = 1'b1;
         end
      end
      @(negedge clk);
      compare();
   endtask

   task automatic drive(bit c, bit w, bit r, logic [7:0] d);
      clr = c; wr_en = w; rd_en = r; wr_data = d;
      cyc();
      clr = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
   endtask

   task automatic fill(int k);
      for (int i = 0; i < k; i++) drive(1'b0, 1'b1, 1'b0, 8'($urandom));
   endtask

   task automatic drain(int k);
      for (int i = 0; i < k; i++) drive(1'b0, 1'b0, 1'b1, 8'h00);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL R1 watchdog expired actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk(fifo_count == 0, "R10 count after reset", int'(fifo_count), 0);
      chk(ovf_flag == 0, "R10 ovf after reset", int'(ovf_flag), 0);
      chk(wl_irq == 0, "R10 irq after reset", int'(wl_irq), 0);
      chk(rd_data == 0, "R10 rd_data after reset", int'(rd_data), 0);

      // R6: transmit, level 8
      rx_mode = 1'b0; tx_lvl_sel = 1'b0;
      fill(20);
      irq_events = 0; irq_at = -1;
      drain(20);
      chk(irq_events == 1, "R6 tx lvl8 pulses", irq_events, 1);
      chk(irq_at == 7, "R6 tx lvl8 crossing", irq_at, 7);

      // R6: transmit, level 16
      tx_lvl_sel = 1'b1;
      fill(20);
      irq_events = 0; irq_at = -1;
      drain(20);
      chk(irq_at == 15, "R6 tx lvl16 crossing", irq_at, 15);

      // R7, R3, R8: receive, level 16, overfill
      rx_mode = 1'b1; rx_lvl_sel = 1'b0;
      irq_events = 0; irq_at = -1;
      fill(40);
      chk(irq_at == 17, "R7 rx lvl16 crossing", irq_at, 17);
      chk(irq_events == 1, "R8 one pulse per crossing", irq_events, 1);
      chk(ovf_flag == 1, "R3 overflow on full write", int'(ovf_flag), 1);
      chk(fifo_count == 32, "R3 excess dropped", int'(fifo_count), 32);

      // R4: sticky through idle and reads
      repeat (5) drive(1'b0, 1'b0, 1'b0, 8'h00);
      drain(32);
      chk(ovf_flag == 1, "R4 ovf sticky", int'(ovf_flag), 1);

      // R2: read on empty
      drive(1'b0, 1'b0, 1'b1, 8'h00);
      chk(fifo_count == 0 && rd_data == 0, "R2 empty read", int'(fifo_count), 0);

      // R5: clear
      drive(1'b1, 1'b0, 1'b0, 8'h00);
      chk(ovf_flag == 0, "R5 clear ovf", int'(ovf_flag), 0);

      // R7: receive, level 24
      rx_lvl_sel = 1'b1;
      irq_events = 0; irq_at = -1;
      fill(32);
      chk(irq_at == 25, "R7 rx lvl24 crossing", irq_at, 25);

      // R9: write and read together on full
      drive(1'b0, 1'b1, 1'b1, 8'hA5);
      chk(fifo_count == 32 && ovf_flag == 0, "R9 full both", int'(fifo_count), 32);

      // R4: transmit-mode discarded write leaves flag clear
      rx_mode = 1'b0;
      drive(1'b0, 1'b1, 1'b0, 8'h3C);
      chk(ovf_flag == 0, "R4 tx drop no ovf", int'(ovf_flag), 0);

      // R5: clear beats a same-cycle write and read
      drive(1'b1, 1'b1, 1'b1, 8'h77);
      chk(fifo_count == 0, "R5 clear priority", int'(fifo_count), 0);
      chk(wl_irq == 0, "R8 no pulse after clear", int'(wl_irq), 0);

      // R9: write and read together on empty
      drive(1'b0, 1'b1, 1'b1, 8'h5A);
      chk(fifo_count == 1 && rd_data == 8'h5A, "R9 empty both", int'(rd_data), 8'h5A);

      // Random collisions of every operation
      for (int blk = 0; blk < 20; blk++) begin
         int wp;
         wp = 30 + int'($urandom % 50);
         for (int i = 0; i < 200; i++) begin
            rx_mode    = ($urandom % 40) == 0 ? ~rx_mode : rx_mode;
            tx_lvl_sel = ($urandom % 60) == 0 ? ~tx_lvl_sel : tx_lvl_sel;
            rx_lvl_sel = ($urandom % 60) == 0 ? ~rx_lvl_sel : rx_lvl_sel;
            drive(($urandom % 150) == 0,
                  int'($urandom % 100) < wp,
                  int'($urandom % 100) < (100 - wp),
                  8'($urandom));
         end
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule